// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state update a processor core needs when it enters an exception handler. A general exception request arrives with the program counter of the faulting instruction, a cause code and, optionally, a faulting virtual address. A debug exception request arrives with its own program counter and debug cause. The block inspects the current processor status: the user-mode bit, the exception-mode bit and the interrupt-level field. From these it picks one of four vector classes and decides which saved-state registers are written.

The block owns the saved-state registers. These are a program-counter register for every interrupt level, a saved-status register for every level from 2 upward, an optional dedicated double-exception PC register, the cause register, the faulting-address register and the debug-cause register. The status register itself belongs to the core. This block returns a write strobe and the new status fields, and the core commits them.

Every update for one entry lands on a single clock edge. In the cycle after the request, a one-cycle take pulse appears together with the vector-select code, which drives the core's fetch redirect.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, `take` and `stat_we` are low and every saved-state register reads zero.
- R2: A general request with exception mode clear writes `gen_pc` into the level-1 PC register. The vector is user (code 0) when the user-mode bit is set and kernel (code 1) otherwise. `take` is high in the cycle after the request for exactly one cycle, and it stays low in any cycle that follows no accepted request.
- R3: A general request with exception mode already set selects the double vector (code 2). When the dedicated double-exception PC register is configured, `gen_pc` goes there and the level-1 PC register is left unchanged.
- R4: When no dedicated double-exception PC register is configured, a double exception writes `gen_pc` into the level-1 PC register, and `depc` reads zero.
- R5: Every general entry writes `gen_cause` into the cause register. It returns a status with exception mode set, with the user-mode bit and the interrupt level unchanged, and with `stat_we` high in the same cycle as `take`.
- R6: The faulting-address register is written with `gen_vaddr` only on a general entry with `gen_has_addr` high. Otherwise it holds its value.
- R7: A debug request is accepted only when `stat_intlevel` is strictly below `DBG_LEVEL`. A masked debug request with no general request raises no `take` and changes no register.
- R8: Debug entry selects the debug vector (code 3). It writes `dbg_pc` into the PC register of level `DBG_LEVEL` and writes the old status into the saved-status register of that level, packed as {user-mode, exception-mode, interrupt-level} with user-mode in the top bit. It writes `dbg_cause` into the debug-cause register. The returned status has the interrupt level set to `DBG_LEVEL`, exception mode set, and the user-mode bit kept. The cause register is not written.
- R9: When a general request and an accepted debug request fall in the same cycle, only the debug entry takes place: the cause, faulting-address, level-1 PC and double PC registers keep their values. When the debug request in that cycle is masked, the general entry proceeds as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_req | input | 1 | General exception request |
| gen_pc | input | XLEN | Faulting program counter |
| gen_cause | input | CAUSE_W | General cause code |
| gen_has_addr | input | 1 | Request carries a faulting address |
| gen_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_pc | input | XLEN | Program counter for debug entry |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| stat_um | input | 1 | Current user-mode status bit |
| stat_excm | input | 1 | Current exception-mode status bit |
| stat_intlevel | input | ILW | Current interrupt level |
| take | output | 1 | One-cycle entry pulse |
| vec_sel | output | 2 | Vector class: 0 user, 1 kernel, 2 double, 3 debug |
| stat_we | output | 1 | Status write strobe for the core |
| stat_new_um | output | 1 | New user-mode bit |
| stat_new_excm | output | 1 | New exception-mode bit |
| stat_new_intlevel | output | ILW | New interrupt level |
| epc_flat | output | NLEVEL*XLEN | PC registers, level L at slice L-1 |
| eps_flat | output | (NLEVEL-1)*(ILW+2) | Saved-status registers, level L at slice L-2 |
| depc | output | XLEN | Double-exception PC register |
| cause | output | CAUSE_W | Cause register |
| vaddr | output | XLEN | Faulting-address register |
| dbgcause | output | DCAUSE_W | Debug-cause register |

## Verification
The two entry paths that can meet in one cycle are a general request and a debug request. The bench raises both together, both at interrupt levels below the debug level and at levels at or above it, through directed cases and a random mix. When both meet, only the debug registers and the debug status may change and the general-path registers must keep their earlier values. When the debug request is masked, the result must match a general-only entry in every register.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        VEC_USER   = 2'd0,
        VEC_KERNEL = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } vec_e;

    // Write controls for one entry, produced by the decision logic.
    typedef struct packed {
        logic take;
        vec_e vec;
        logic wr_epc1;
        logic wr_epc_dbg;
        logic wr_eps_dbg;
        logic wr_depc;
        logic wr_cause;
        logic wr_vaddr;
        logic wr_dcause;
        logic force_dbg_lvl;
    } ent_ctl_t;

    function automatic vec_e general_vector(input logic excm, input logic um);
        if (excm)    return VEC_DOUBLE;
        else if (um) return VEC_USER;
        else         return VEC_KERNEL;
    endfunction

endpackage

// File: rtl/exc_decide.sv
module exc_decide
    import exc_entry_pkg::*;
#(
    parameter int ILW       = 4,
    parameter int DBG_LEVEL = 6,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic           gen_req,
    input  logic           gen_has_addr,
    input  logic           dbg_req,
    input  logic           stat_excm,
    input  logic           stat_um,
    input  logic [ILW-1:0] stat_intlevel,
    output ent_ctl_t       ctl
);
    localparam logic [ILW-1:0] DBG_LV = ILW'(DBG_LEVEL);

    logic dbg_ok;

    always_comb begin
        dbg_ok = dbg_req && (stat_intlevel < DBG_LV);
        ctl    = '0;
        if (dbg_ok) begin
            // Debug entry has priority over a general request in the same cycle.
            ctl.take          = 1'b1;
            ctl.vec           = VEC_DEBUG;
            ctl.wr_epc_dbg    = 1'b1;
            ctl.wr_eps_dbg    = 1'b1;
            ctl.wr_dcause     = 1'b1;
            ctl.force_dbg_lvl = 1'b1;
        end else if (gen_req) begin
            ctl.take     = 1'b1;
            ctl.vec      = general_vector(stat_excm, stat_um);
            ctl.wr_cause = 1'b1;
            ctl.wr_vaddr = gen_has_addr;
            if (stat_excm && HAS_DEPC) ctl.wr_depc = 1'b1;
            else                       ctl.wr_epc1 = 1'b1;
        end
    end

    // R7: a masked debug request alone never produces an entry
    always_comb begin
        if (dbg_req && !gen_req && (stat_intlevel >= DBG_LV))
            a_r7_masked_no_take: assert (!ctl.take);
    end

endmodule

// File: rtl/exc_savebank.sv
module exc_savebank
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NLEVEL    = 6,
    parameter int SW        = 6,
    parameter int DBG_LEVEL = 6,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ent_ctl_t                   ctl,
    input  logic [XLEN-1:0]            gen_pc,
    input  logic [XLEN-1:0]            dbg_pc,
    input  logic [SW-1:0]              stat_packed,
    output logic [NLEVEL*XLEN-1:0]     epc_flat,
    output logic [(NLEVEL-1)*SW-1:0]   eps_flat,
    output logic [XLEN-1:0]            depc
);

    // PC register per level 1..NLEVEL
    for (genvar l = 1; l <= NLEVEL; l++) begin : g_epc
        logic [XLEN-1:0] q;
        logic            we_gen;
        logic            we_dbg;
        assign we_gen = (l == 1) && ctl.wr_epc1;
        assign we_dbg = (l == DBG_LEVEL) && ctl.wr_epc_dbg;
        always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (we_dbg) q <= dbg_pc;
            else if (we_gen) q <= gen_pc;
        end
        assign epc_flat[(l-1)*XLEN +: XLEN] = q;
    end

    // Saved-status register per level 2..NLEVEL
    for (genvar l = 2; l <= NLEVEL; l++) begin : g_eps
        logic [SW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                   q <= '0;
            else if ((l == DBG_LEVEL) && ctl.wr_eps_dbg) q <= stat_packed;
        end
        assign eps_flat[(l-2)*SW +: SW] = q;
    end

    if (HAS_DEPC) begin : g_depc
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)              q <= '0;
            else if (ctl.wr_depc) q <= gen_pc;
        end
        assign depc = q;
    end else begin : g_no_depc
        assign depc = '0;
    end

    // R3: a double entry routed to the dedicated register leaves level 1 alone
    a_r3_epc1_kept: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_depc |=> $stable(epc_flat[XLEN-1:0]));

    // R4: without the dedicated register it always reads zero
    a_r4_depc_zero: assert property (@(posedge clk) disable iff (rst)
        !HAS_DEPC |-> depc == '0);

endmodule

// File: rtl/exc_causebank.sv
module exc_causebank
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 6,
    parameter int DCAUSE_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  ent_ctl_t            ctl,
    input  logic [CAUSE_W-1:0]  gen_cause,
    input  logic [XLEN-1:0]     gen_vaddr,
    input  logic [DCAUSE_W-1:0] dbg_cause,
    output logic [CAUSE_W-1:0]  cause,
    output logic [XLEN-1:0]     vaddr,
    output logic [DCAUSE_W-1:0] dbgcause
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause    <= '0;
            vaddr    <= '0;
            dbgcause <= '0;
        end else begin
            if (ctl.wr_cause)  cause    <= gen_cause;
            if (ctl.wr_vaddr)  vaddr    <= gen_vaddr;
            if (ctl.wr_dcause) dbgcause <= dbg_cause;
        end
    end

    // R6: the faulting address only moves on an entry that carries one
    a_r6_vaddr_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.wr_vaddr |=> $stable(vaddr));

    // R8: a debug entry never disturbs the general cause register
    a_r8_cause_kept: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_dcause |=> $stable(cause));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NLEVEL    = 6,
    parameter int ILW       = 4,
    parameter int DBG_LEVEL = 6,
    parameter int CAUSE_W   = 6,
    parameter int DCAUSE_W  = 6,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          gen_req,
    input  logic [XLEN-1:0]               gen_pc,
    input  logic [CAUSE_W-1:0]            gen_cause,
    input  logic                          gen_has_addr,
    input  logic [XLEN-1:0]               gen_vaddr,
    input  logic                          dbg_req,
    input  logic [XLEN-1:0]               dbg_pc,
    input  logic [DCAUSE_W-1:0]           dbg_cause,
    input  logic                          stat_um,
    input  logic                          stat_excm,
    input  logic [ILW-1:0]                stat_intlevel,
    output logic                          take,
    output logic [1:0]                    vec_sel,
    output logic                          stat_we,
    output logic                          stat_new_um,
    output logic                          stat_new_excm,
    output logic [ILW-1:0]                stat_new_intlevel,
    output logic [NLEVEL*XLEN-1:0]        epc_flat,
    output logic [(NLEVEL-1)*(ILW+2)-1:0] eps_flat,
    output logic [XLEN-1:0]               depc,
    output logic [CAUSE_W-1:0]            cause,
    output logic [XLEN-1:0]               vaddr,
    output logic [DCAUSE_W-1:0]           dbgcause
);
    localparam int             SW     = ILW + 2;
    localparam logic [ILW-1:0] DBG_LV = ILW'(DBG_LEVEL);

    ent_ctl_t      ctl;
    logic [SW-1:0] stat_packed;

    assign stat_packed = {stat_um, stat_excm, stat_intlevel};

    exc_decide #(.ILW(ILW), .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_decide (
        .gen_req      (gen_req),
        .gen_has_addr (gen_has_addr),
        .dbg_req      (dbg_req),
        .stat_excm    (stat_excm),
        .stat_um      (stat_um),
        .stat_intlevel(stat_intlevel),
        .ctl          (ctl)
    );

    exc_savebank #(.XLEN(XLEN), .NLEVEL(NLEVEL), .SW(SW),
                   .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_save (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .gen_pc     (gen_pc),
        .dbg_pc     (dbg_pc),
        .stat_packed(stat_packed),
        .epc_flat   (epc_flat),
        .eps_flat   (eps_flat),
        .depc       (depc)
    );

    exc_causebank #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W)) u_cause (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .gen_cause(gen_cause),
        .gen_vaddr(gen_vaddr),
        .dbg_cause(dbg_cause),
        .cause    (cause),
        .vaddr    (vaddr),
        .dbgcause (dbgcause)
    );

    // Take pulse, vector and new status, all on the same edge as the saves.
    always_ff @(posedge clk) begin
        if (rst) begin
            take              <= 1'b0;
            vec_sel           <= 2'(VEC_USER);
            stat_we           <= 1'b0;
            stat_new_um       <= 1'b0;
            stat_new_excm     <= 1'b0;
            stat_new_intlevel <= '0;
        end else begin
            take    <= ctl.take;
            stat_we <= ctl.take;
            if (ctl.take) begin
                vec_sel           <= 2'(ctl.vec);
                stat_new_um       <= stat_um;
                stat_new_excm     <= 1'b1;
                stat_new_intlevel <= ctl.force_dbg_lvl ? DBG_LV : stat_intlevel;
            end
        end
    end

    // R2: an entry pulse always follows a request in the cycle before
    a_r2_take_has_req: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(gen_req || dbg_req));

    // R5: every entry returns exception mode set, with the strobe
    a_r5_excm_set: assert property (@(posedge clk) disable iff (rst)
        take |-> (stat_new_excm && stat_we));

    // R3: general request in exception mode without debug gives the double vector
    a_r3_double_vec: assert property (@(posedge clk) disable iff (rst)
        (gen_req && !dbg_req && stat_excm) |=> (take && vec_sel == 2'(VEC_DOUBLE)));

    // R8: a debug entry forces the configured level
    a_r8_dbg_level: assert property (@(posedge clk) disable iff (rst)
        (take && vec_sel == 2'(VEC_DEBUG)) |-> stat_new_intlevel == DBG_LV);

    // R9: an accepted debug request wins over a simultaneous general one
    a_r9_dbg_wins: assert property (@(posedge clk) disable iff (rst)
        (gen_req && dbg_req && stat_intlevel < DBG_LV) |=> vec_sel == 2'(VEC_DEBUG));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NLEVEL = 6;
    localparam int ILW = 4;
    localparam int DBGL = 6;
    localparam int SW = ILW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            gen_req = 0, gen_has_addr = 0, dbg_req = 0;
    logic [31:0]     gen_pc = 0, gen_vaddr = 0, dbg_pc = 0;
    logic [5:0]      gen_cause = 0, dbg_cause = 0;
    logic            stat_um = 0, stat_excm = 0;
    logic [ILW-1:0]  stat_intlevel = 0;

    logic            take, stat_we, n_um, n_excm;
    logic [1:0]      vec_sel;
    logic [ILW-1:0]  n_il;
    logic [NLEVEL*XLEN-1:0]   epc_flat;
    logic [(NLEVEL-1)*SW-1:0] eps_flat;
    logic [31:0]     depc, vaddr;
    logic [5:0]      cause, dbgcause;

    logic            take_nd, we_nd, um_nd, excm_nd;
    logic [1:0]      vec_nd;
    logic [ILW-1:0]  il_nd;
    logic [NLEVEL*XLEN-1:0]   epc_nd;
    logic [(NLEVEL-1)*SW-1:0] eps_nd;
    logic [31:0]     depc_nd, vaddr_nd;
    logic [5:0]      cause_nd, dcause_nd;

    exc_entry_ctrl dut (
        .clk(clk), .rst(rst), .gen_req(gen_req), .gen_pc(gen_pc), .gen_cause(gen_cause),
        .gen_has_addr(gen_has_addr), .gen_vaddr(gen_vaddr), .dbg_req(dbg_req),
        .dbg_pc(dbg_pc), .dbg_cause(dbg_cause), .stat_um(stat_um), .stat_excm(stat_excm),
        .stat_intlevel(stat_intlevel), .take(take), .vec_sel(vec_sel), .stat_we(stat_we),
        .stat_new_um(n_um), .stat_new_excm(n_excm), .stat_new_intlevel(n_il),
        .epc_flat(epc_flat), .eps_flat(eps_flat), .depc(depc), .cause(cause),
        .vaddr(vaddr), .dbgcause(dbgcause));

    exc_entry_ctrl #(.HAS_DEPC(1'b0)) dut_nodepc (
        .clk(clk), .rst(rst), .gen_req(gen_req), .gen_pc(gen_pc), .gen_cause(gen_cause),
        .gen_has_addr(gen_has_addr), .gen_vaddr(gen_vaddr), .dbg_req(dbg_req),
        .dbg_pc(dbg_pc), .dbg_cause(dbg_cause), .stat_um(stat_um), .stat_excm(stat_excm),
        .stat_intlevel(stat_intlevel), .take(take_nd), .vec_sel(vec_nd), .stat_we(we_nd),
        .stat_new_um(um_nd), .stat_new_excm(excm_nd), .stat_new_intlevel(il_nd),
        .epc_flat(epc_nd), .eps_flat(eps_nd), .depc(depc_nd), .cause(cause_nd),
        .vaddr(vaddr_nd), .dbgcause(dcause_nd));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected state
    logic [31:0] e_epc [1:NLEVEL];
    logic [SW-1:0] e_eps [2:NLEVEL];
    logic [31:0] e_depc, e_vaddr, e_epc1_nd;
    logic [5:0]  e_cause, e_dcause;
    logic        e_take, e_um, e_excm;
    logic [1:0]  e_vec;
    logic [ILW-1:0] e_il;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_vec_gen(input logic excm, input logic um);
        if (excm) return 2'd2;
        return um ? 2'd0 : 2'd1;
    endfunction

    task automatic model_reset();
        for (int l = 1; l <= NLEVEL; l++) e_epc[l] = '0;
        for (int l = 2; l <= NLEVEL; l++) e_eps[l] = '0;
        e_depc = 0; e_vaddr = 0; e_epc1_nd = 0; e_cause = 0; e_dcause = 0;
        e_take = 0; e_um = 0; e_excm = 0; e_vec = 0; e_il = 0;
    endtask

    // model of one edge from the held inputs
    task automatic model_step();
        logic dbg_ok;
        dbg_ok = dbg_req && (int'(stat_intlevel) < DBGL);
        e_take = dbg_ok || gen_req;
        if (dbg_ok) begin
            e_vec = 2'd3;
            e_epc[DBGL] = dbg_pc;
            e_eps[DBGL] = {stat_um, stat_excm, stat_intlevel};
            e_dcause = dbg_cause;
            e_um = stat_um; e_excm = 1'b1; e_il = ILW'(DBGL);
        end else if (gen_req) begin
            e_vec = exp_vec_gen(stat_excm, stat_um);
            if (stat_excm) e_depc = gen_pc; else e_epc[1] = gen_pc;
            e_epc1_nd = gen_pc;
            e_cause = gen_cause;
            if (gen_has_addr) e_vaddr = gen_vaddr;
            e_um = stat_um; e_excm = 1'b1; e_il = stat_intlevel;
        end
    endtask

    task automatic check_all(input string ctx);
        string g;
        g = (dbg_req && gen_req) ? "R9" : "";
        chk({"R2 take ", ctx}, 32'(take), 32'(e_take));
        chk({"R5 stat_we ", ctx}, 32'(stat_we), 32'(e_take));
        if (e_take) chk({"R2/R3/R8 vec ", ctx}, 32'(vec_sel), 32'(e_vec));
        chk({"R5 new status ", ctx}, {29'd0, n_um, n_excm, 1'b0} | 32'(n_il) << 4,
            {29'd0, e_um, e_excm, 1'b0} | 32'(e_il) << 4);
        chk({"R2 epc1 ", g, " ", ctx}, epc_flat[31:0], e_epc[1]);
        chk({"R3 depc ", g, " ", ctx}, depc, e_depc);
        chk({"R8 epc dbg ", ctx}, epc_flat[(DBGL-1)*32 +: 32], e_epc[DBGL]);
        chk({"R8 eps dbg ", ctx}, 32'(eps_flat[(DBGL-2)*SW +: SW]), 32'(e_eps[DBGL]));
        chk({"R5 cause ", g, " ", ctx}, 32'(cause), 32'(e_cause));
        chk({"R6 vaddr ", g, " ", ctx}, vaddr, e_vaddr);
        chk({"R8 dbgcause ", ctx}, 32'(dbgcause), 32'(e_dcause));
        chk({"R4 epc1 nodepc ", ctx}, epc_nd[31:0], e_epc1_nd);
        chk({"R4 depc nodepc ", ctx}, depc_nd, 32'd0);
        for (int l = 2; l <= NLEVEL; l++)
            if (l != DBGL) chk({"R7 other level ", ctx}, epc_flat[(l-1)*32 +: 32], 32'd0);
    endtask

    task automatic apply(input string ctx, input bit g, input bit ga, input bit d,
                         input bit e, input bit u, input logic [ILW-1:0] il);
        gen_req = g; gen_has_addr = ga; dbg_req = d;
        stat_excm = e; stat_um = u; stat_intlevel = il;
        gen_pc = $urandom; gen_vaddr = $urandom; dbg_pc = $urandom;
        gen_cause = 6'($urandom); dbg_cause = 6'($urandom);
        @(negedge clk);
        model_step();
        check_all(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check_all("R1 reset");
        apply("R2 kernel", 1, 0, 0, 0, 0, 4'd0);
        apply("R2 user", 1, 1, 0, 0, 1, 4'd2);
        apply("R2 idle", 0, 0, 0, 0, 0, 4'd0);
        apply("R3 double", 1, 1, 0, 1, 1, 4'd1);
        apply("R6 no addr", 1, 0, 0, 0, 0, 4'd0);
        apply("R8 debug below", 0, 0, 1, 1, 1, 4'd5);
        apply("R7 debug masked eq", 0, 0, 1, 0, 0, 4'd6);
        apply("R7 debug masked hi", 0, 0, 1, 0, 1, 4'd9);
        apply("R9 both", 1, 1, 1, 0, 0, 4'd3);
        apply("R9 both masked", 1, 1, 1, 1, 0, 4'd7);
        apply("R9 both excm", 1, 1, 1, 1, 1, 4'd0);
        for (int i = 0; i < 400; i++) begin
            apply("random", ($urandom % 10) < 6, $urandom % 2, ($urandom % 10) < 3,
                  ($urandom % 10) < 4, $urandom % 2, ILW'($urandom % 9));
        end
        apply("R2 drain", 0, 0, 0, 0, 0, 4'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule